// File: doc/BRIEF.md
# Asynchronous Static Memory Bus Controller

This block converts internal single-beat read and write requests into timed cycles on an external parallel memory bus. The bus is asynchronous and does not multiplex address and data, so it suits NOR flash and SRAM. Up to four banks share the address, output-enable, write-enable and data lines. Each bank has its own active-low chip select.

Every bank keeps a control word and two timing words. A timing word sets the length, in clock cycles, of three phases: address setup, address hold and data. The hold phase may be zero cycles long. A wait input can stretch the data phase. Its active level is programmable, and it can act on the cycle it is seen or one cycle later. An extended mode gives writes their own timing word. Without extended mode, reads and writes share the primary timing word.

Requests and responses each use a valid/ready handshake. Only one access is in flight at a time. `req_ready` is high only while the block is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. The response stays on `rsp_valid` with stable data and error until `rsp_ready` accepts it, and no new request is taken before then. The data bus is shown as three split pins: output value, output enable and input sample.

Top module: `async_mem_ctrl`

## Requirements
- R1: During and right after reset, all chip selects, `mem_oe_n` and `mem_we_n` are high, `mem_dq_oe` is low, `req_ready` is high and `rsp_valid` is low.
- R2: A read asserts only the selected bank's chip select for setup+hold+data cycles. `mem_oe_n` is low only for the final data-phase cycles, and `mem_we_n` stays high. `mem_dq_oe` stays low. The response data is `mem_dq_i` as sampled in the last data cycle. The address is stable while the chip select is low.
- R3: A write holds `mem_we_n` low only for the data-phase cycles and never lowers `mem_oe_n`. It drives `mem_dq_oe` high with the write data on `mem_dq_o` for every cycle the chip select is low.
- R4: A hold count of 0 skips the hold phase. A setup or data count of 0 acts as 1.
- R5: When control bit 3 (extended) is clear, writes use the primary timing word. When it is set, writes use the write timing word and reads still use the primary one.
- R6: When control bit 1 (16-bit) is set, `mem_addr` is the request byte address shifted right by one. When it is clear, `mem_addr` is the byte address. In that case write data goes out as the low byte with the upper byte zero, and read data returns only the low byte, zero-extended.
- R7: A write to a bank whose control bit 2 (write allowed) is clear, and any access to a bank whose control bit 0 (enable) is clear, produce no chip select and return `rsp_err`=1.
- R8: When control bit 4 (wait enable) is set, the data phase ends at the first cycle that is at or past its programmed length with `mem_wait` not at its active level. Control bit 5 selects active-high (1) or active-low (0). When bit 4 is clear, `mem_wait` has no effect.
- R9: When control bit 6 (delayed wait) is set, the wait check uses `mem_wait` as registered one cycle earlier.
- R10: `req_ready` is low from acceptance until the response is taken. While `rsp_valid` is high and `rsp_ready` is low, the response holds stable.
- R11: At most one chip select is low at any time.
- R12: After reset every bank's control word is 16-bit with writes allowed and the bank disabled (0x06). Both timing words are setup 2, hold 0, data 5. Configuration writes use `cfg_sel` 0 for control, 1 for primary timing and 2 for write timing. A timing word has setup in bits 3:0, hold in bits 7:4 and data in bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bank | input | 2 | Bank targeted by the configuration write |
| cfg_sel | input | 2 | Word select: 0 control, 1 primary timing, 2 write timing |
| cfg_wdata | input | 16 | Configuration value |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bank | input | 2 | Target bank |
| req_addr | input | 20 | Byte address inside the bank |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken when high together with valid |
| rsp_rdata | output | 16 | Read data |
| rsp_err | output | 1 | Access refused |
| mem_ce_n | output | 4 | Per-bank chip selects, active low |
| mem_addr | output | 20 | External address |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_o | output | 16 | Data driven to memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | 16 | Data sampled from memory |
| mem_wait | input | 1 | Wait from memory |

## Verification
The bench exercises the phase sequencer with several timing words. These include an asymmetric setup/hold/data set, the all-zero word, a zero-hold word and the reset word. Each pattern is checked by the exact number of chip-select, output-enable and write-enable cycles, which tells a skipped, clamped or miscounted phase apart. Writes are run with extended mode off and then on, against a bank whose two timing words differ, which shows which word was used. The 8-bit and 16-bit lanes are told apart by the address seen on the bus and by the byte returned from an address-keyed memory model. Wait pulses of known length are applied with both polarities, in both wait-sampling modes and with wait disabled, and each gives a different data-phase length.

// File: rtl/amc_pkg.sv
package amc_pkg;
  localparam int SET_W = 4;
  localparam int HLD_W = 4;
  localparam int DAT_W = 8;
  localparam int TIM_W = SET_W + HLD_W + DAT_W;

  typedef struct packed {
    logic [DAT_W-1:0] data;
    logic [HLD_W-1:0] hold;
    logic [SET_W-1:0] setup;
  } tim_t;

  typedef struct packed {
    logic wait_reg;
    logic wait_hi;
    logic wait_en;
    logic ext_mode;
    logic wr_allow;
    logic wide;
    logic enable;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_RD   = 2'd1;
  localparam logic [1:0] SEL_WR   = 2'd2;

  localparam ctrl_t CTRL_RST = '{wait_reg: 1'b0, wait_hi: 1'b0, wait_en: 1'b0,
                                 ext_mode: 1'b0, wr_allow: 1'b1, wide: 1'b1,
                                 enable: 1'b0};
  localparam tim_t TIM_RST = '{data: DAT_W'(5), hold: HLD_W'(0), setup: SET_W'(2)};

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_HOLD, PH_DATA, PH_RESP
  } phase_e;
endpackage

// File: rtl/amc_bank_cfg.sv
module amc_bank_cfg
  import amc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       sel,
  input  logic [TIM_W-1:0] wdata,
  output ctrl_t            ctrl,
  output tim_t             rd_tim,
  output tim_t             wr_tim
);
  logic unused_hi;
  assign unused_hi = ^wdata[TIM_W-1:CTRL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= CTRL_RST;
      rd_tim <= TIM_RST;
      wr_tim <= TIM_RST;
    end else if (wr_en) begin
      case (sel)
        SEL_CTRL: ctrl   <= ctrl_t'(wdata[CTRL_W-1:0]);
        SEL_RD:   rd_tim <= tim_t'(wdata);
        SEL_WR:   wr_tim <= tim_t'(wdata);
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/amc_lane_map.sv
module amc_lane_map #(
  parameter int ADDR_W = 20,
  parameter int DQ_W   = 16
) (
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DQ_W-1:0]   req_wdata,
  input  logic              cap_wide,
  input  logic [DQ_W-1:0]   dq_in,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DQ_W-1:0]   lane_wdata,
  output logic [DQ_W-1:0]   lane_rdata
);
  localparam int HALF = DQ_W / 2;

  always_comb begin
    if (req_wide) begin
      ext_addr   = req_addr >> 1;
      lane_wdata = req_wdata;
    end else begin
      ext_addr   = req_addr;
      lane_wdata = {{(DQ_W-HALF){1'b0}}, req_wdata[HALF-1:0]};
    end
    lane_rdata = cap_wide ? dq_in : {{(DQ_W-HALF){1'b0}}, dq_in[HALF-1:0]};
  end
endmodule

// File: rtl/amc_phase_fsm.sv
module amc_phase_fsm
  import amc_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int ADDR_W = 20,
  parameter int DQ_W   = 16,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [DQ_W-1:0]   lane_wdata,
  input  ctrl_t             sel_ctrl,
  input  tim_t              sel_rd,
  input  tim_t              sel_wr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DQ_W-1:0]   rsp_rdata,
  output logic              rsp_err,
  output logic              cap_wide,
  input  logic [DQ_W-1:0]   lane_rdata,
  output logic [BANKS-1:0]  mem_ce_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DQ_W-1:0]   mem_dq_o,
  output logic              mem_dq_oe,
  input  logic              mem_wait
);
  phase_e             st;
  logic [BANK_W-1:0]  bank_q;
  logic               wr_q, wide_q, err_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DQ_W-1:0]    wdat_q, rdat_q;
  logic [HLD_W-1:0]   hold_q;
  logic [DAT_W-1:0]   data_q, cnt;
  logic               wen_q, whi_q, wreg_q, wait_ff;

  tim_t               tim_pick;
  logic               deny, wait_raw, stall, busy;
  logic [SET_W-1:0]   set_eff;
  logic [DAT_W-1:0]   dat_eff;

  always_comb begin
    tim_pick = (req_write && sel_ctrl.ext_mode) ? sel_wr : sel_rd;
    deny     = !sel_ctrl.enable || (req_write && !sel_ctrl.wr_allow);
    set_eff  = (tim_pick.setup == '0) ? SET_W'(1) : tim_pick.setup;
    dat_eff  = (tim_pick.data == '0) ? DAT_W'(1) : tim_pick.data;
    wait_raw = wreg_q ? wait_ff : mem_wait;
    stall    = wen_q && (wait_raw == whi_q);
    busy     = (st == PH_SETUP) || (st == PH_HOLD) || (st == PH_DATA);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= PH_IDLE;
      bank_q  <= '0;
      wr_q    <= 1'b0;
      wide_q  <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      wdat_q  <= '0;
      rdat_q  <= '0;
      hold_q  <= '0;
      data_q  <= '0;
      cnt     <= '0;
      wen_q   <= 1'b0;
      whi_q   <= 1'b0;
      wreg_q  <= 1'b0;
      wait_ff <= 1'b0;
    end else begin
      wait_ff <= mem_wait;
      case (st)
        PH_IDLE: begin
          if (req_valid) begin
            bank_q <= req_bank;
            wr_q   <= req_write;
            wide_q <= sel_ctrl.wide;
            addr_q <= ext_addr;
            wdat_q <= lane_wdata;
            rdat_q <= '0;
            hold_q <= tim_pick.hold;
            data_q <= dat_eff;
            wen_q  <= sel_ctrl.wait_en;
            whi_q  <= sel_ctrl.wait_hi;
            wreg_q <= sel_ctrl.wait_reg;
            cnt    <= DAT_W'(set_eff) - DAT_W'(1);
            err_q  <= deny;
            st     <= deny ? PH_RESP : PH_SETUP;
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            if (hold_q == '0) begin
              cnt <= data_q - DAT_W'(1);
              st  <= PH_DATA;
            end else begin
              cnt <= DAT_W'(hold_q) - DAT_W'(1);
              st  <= PH_HOLD;
            end
          end else begin
            cnt <= cnt - DAT_W'(1);
          end
        end
        PH_HOLD: begin
          if (cnt == '0) begin
            cnt <= data_q - DAT_W'(1);
            st  <= PH_DATA;
          end else begin
            cnt <= cnt - DAT_W'(1);
          end
        end
        PH_DATA: begin
          if (cnt != '0) begin
            cnt <= cnt - DAT_W'(1);
          end else if (!stall) begin
            if (!wr_q) rdat_q <= lane_rdata;
            st <= PH_RESP;
          end
        end
        PH_RESP: if (rsp_ready) st <= PH_IDLE;
        default: st <= PH_IDLE;
      endcase
    end
  end

  assign req_ready = (st == PH_IDLE);
  assign rsp_valid = (st == PH_RESP);
  assign rsp_rdata = rdat_q;
  assign rsp_err   = err_q;
  assign cap_wide  = wide_q;
  assign mem_ce_n  = busy ? ~(BANKS'(1) << bank_q) : '1;
  assign mem_oe_n  = !((st == PH_DATA) && !wr_q);
  assign mem_we_n  = !((st == PH_DATA) && wr_q);
  assign mem_dq_oe = busy && wr_q;
  assign mem_dq_o  = wdat_q;
  assign mem_addr  = addr_q;
endmodule

// File: rtl/async_mem_ctrl.sv
module async_mem_ctrl
  import amc_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int ADDR_W = 20,
  parameter int DQ_W   = 16,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [BANK_W-1:0] cfg_bank,
  input  logic [1:0]        cfg_sel,
  input  logic [TIM_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DQ_W-1:0]   req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DQ_W-1:0]   rsp_rdata,
  output logic              rsp_err,
  output logic [BANKS-1:0]  mem_ce_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DQ_W-1:0]   mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DQ_W-1:0]   mem_dq_i,
  input  logic              mem_wait
);
  ctrl_t ctrl_a [BANKS];
  tim_t  rd_a   [BANKS];
  tim_t  wr_a   [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    amc_bank_cfg u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_we && (cfg_bank == BANK_W'(b))),
      .sel    (cfg_sel),
      .wdata  (cfg_wdata),
      .ctrl   (ctrl_a[b]),
      .rd_tim (rd_a[b]),
      .wr_tim (wr_a[b])
    );
  end

  ctrl_t             sel_ctrl;
  tim_t              sel_rd, sel_wr;
  logic [ADDR_W-1:0] ext_addr;
  logic [DQ_W-1:0]   lane_wdata, lane_rdata;
  logic              cap_wide;

  assign sel_ctrl = ctrl_a[req_bank];
  assign sel_rd   = rd_a[req_bank];
  assign sel_wr   = wr_a[req_bank];

  amc_lane_map #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_lane (
    .req_wide   (sel_ctrl.wide),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .cap_wide   (cap_wide),
    .dq_in      (mem_dq_i),
    .ext_addr   (ext_addr),
    .lane_wdata (lane_wdata),
    .lane_rdata (lane_rdata)
  );

  amc_phase_fsm #(.BANKS(BANKS), .ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_bank   (req_bank),
    .ext_addr   (ext_addr),
    .lane_wdata (lane_wdata),
    .sel_ctrl   (sel_ctrl),
    .sel_rd     (sel_rd),
    .sel_wr     (sel_wr),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_rdata  (rsp_rdata),
    .rsp_err    (rsp_err),
    .cap_wide   (cap_wide),
    .lane_rdata (lane_rdata),
    .mem_ce_n   (mem_ce_n),
    .mem_addr   (mem_addr),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_o   (mem_dq_o),
    .mem_dq_oe  (mem_dq_oe),
    .mem_wait   (mem_wait)
  );
endmodule

// File: rtl/amc_chk.sv
module amc_chk #(
  parameter int BANKS  = 4,
  parameter int ADDR_W = 20,
  parameter int DQ_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BANKS-1:0]  mem_ce_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DQ_W-1:0]   rsp_rdata,
  input logic              rsp_err
);
  assert_one_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_ce_n));

  assert_strobes_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_dq_oe && !(&mem_ce_n)));

  assert_addr_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&mem_ce_n) && $past(!(&mem_ce_n))) |-> $stable(mem_addr));

  assert_write_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_dq_oe && mem_oe_n));

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  assert_bus_idle_on_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (&mem_ce_n));
endmodule

bind async_mem_ctrl amc_chk #(.BANKS(BANKS), .ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_ce_n  (mem_ce_n),
  .mem_addr  (mem_addr),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err)
);

// File: tb/async_mem_ctrl_tb.sv
module async_mem_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_bank = '0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [15:0] rsp_rdata;
  logic        rsp_err;
  logic [3:0]  mem_ce_n;
  logic [19:0] mem_addr;
  logic        mem_oe_n, mem_we_n, mem_dq_oe;
  logic [15:0] mem_dq_o, mem_dq_i;
  logic        mem_wait = 1'b1;

  int total = 0;
  int bad = 0;

  // measurement results of the last access
  int n_ce, n_any, n_oe, n_we, n_dq, n_other, n_rdy;
  logic [19:0] cap_addr;
  logic [15:0] cap_dq, got_rdata;
  logic        got_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] model(input logic [19:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  assign mem_dq_i = model(mem_addr);

  async_mem_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bank(req_bank), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .mem_ce_n(mem_ce_n), .mem_addr(mem_addr), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i), .mem_wait(mem_wait)
  );

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic chk(input string rq, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [15:0] tim(input int s, input int h, input int d);
    return {8'(d), 4'(h), 4'(s)};
  endfunction

  task automatic cfg(input int b, input logic [1:0] sel, input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = 2'(b); cfg_sel = sel; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one access; wk = data cycles with wait active, wpol = active level
  task automatic access(input int b, input bit wr, input logic [19:0] a,
                        input logic [15:0] wd, input int wk, input bit wpol,
                        input int hold_rsp);
    int di;
    @(negedge clk);
    n_ce = 0; n_any = 0; n_oe = 0; n_we = 0; n_dq = 0; n_other = 0; n_rdy = 0;
    cap_addr = '0; cap_dq = '0; di = 0;
    mem_wait = ~wpol;
    req_valid = 1'b1; req_write = wr; req_bank = 2'(b); req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) begin
      if (mem_ce_n != 4'hF) begin
        n_any++;
        if (!mem_ce_n[b]) n_ce++;
        if (mem_ce_n != ~(4'b0001 << b)) n_other++;
        if (req_ready) n_rdy++;
        cap_addr = mem_addr;
      end
      if (mem_dq_oe) begin n_dq++; cap_dq = mem_dq_o; end
      if (!mem_oe_n) n_oe++;
      if (!mem_we_n) n_we++;
      if (!mem_oe_n || !mem_we_n) begin
        di++;
        mem_wait = (di <= wk) ? wpol : ~wpol;
      end else begin
        mem_wait = ~wpol;
      end
      @(negedge clk);
    end
    mem_wait = ~wpol;
    got_rdata = rsp_rdata;
    got_err = rsp_err;
    for (int i = 0; i < hold_rsp; i++) begin
      @(negedge clk);
      chk("R10", "rsp_valid held", 32'(rsp_valid), 32'd1);
      chk("R10", "req_ready low while rsp pending", 32'(req_ready), 32'd0);
      chk("R10", "rdata stable", 32'(rsp_rdata), 32'(got_rdata));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "ce_n", 32'(mem_ce_n), 32'hF);
    chk("R1", "oe_n", 32'(mem_oe_n), 32'd1);
    chk("R1", "we_n", 32'(mem_we_n), 32'd1);
    chk("R1", "dq_oe", 32'(mem_dq_oe), 32'd0);
    chk("R1", "req_ready", 32'(req_ready), 32'd1);
    chk("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_reset_cfg();
    cfg(0, 2'd0, 16'h0007);
    access(0, 1'b0, 20'h00010, 16'h0, 0, 1'b0, 0);
    chk("R12", "ce cycles default", n_ce, 7);
    chk("R12", "oe cycles default", n_oe, 5);
    chk("R12", "addr default wide", 32'(cap_addr), 32'h8);
    chk("R12", "rdata", 32'(got_rdata), 32'(model(20'h8)));
  endtask

  task automatic t_read();
    cfg(1, 2'd0, 16'h0007);
    cfg(1, 2'd1, tim(3, 2, 4));
    access(1, 1'b0, 20'h01234, 16'h0, 0, 1'b0, 0);
    chk("R2", "ce cycles", n_ce, 9);
    chk("R2", "oe cycles", n_oe, 4);
    chk("R2", "we cycles", n_we, 0);
    chk("R2", "dq_oe cycles", n_dq, 0);
    chk("R2", "rdata", 32'(got_rdata), 32'(model(20'h0091A)));
    chk("R6", "wide addr", 32'(cap_addr), 32'h0091A);
    chk("R11", "other selects", n_other, 0);
    chk("R10", "ready while busy", n_rdy, 0);
  endtask

  task automatic t_write();
    access(1, 1'b1, 20'h00402, 16'hC0DE, 0, 1'b0, 0);
    chk("R3", "ce cycles", n_ce, 9);
    chk("R3", "we cycles", n_we, 4);
    chk("R3", "oe cycles", n_oe, 0);
    chk("R3", "dq_oe cycles", n_dq, 9);
    chk("R3", "dq value", 32'(cap_dq), 32'hC0DE);
    chk("R3", "err", 32'(got_err), 32'd0);
    chk("R11", "other selects", n_other, 0);
  endtask

  task automatic t_zero();
    cfg(1, 2'd1, tim(0, 0, 0));
    access(1, 1'b0, 20'h00002, 16'h0, 0, 1'b0, 0);
    chk("R4", "ce cycles all-zero", n_ce, 2);
    chk("R4", "oe cycles all-zero", n_oe, 1);
    chk("R4", "rdata", 32'(got_rdata), 32'(model(20'h1)));
    cfg(1, 2'd1, tim(1, 0, 3));
    access(1, 1'b0, 20'h00002, 16'h0, 0, 1'b0, 0);
    chk("R4", "ce cycles zero hold", n_ce, 4);
    chk("R4", "oe cycles zero hold", n_oe, 3);
  endtask

  task automatic t_extended();
    cfg(2, 2'd0, 16'h0007);
    cfg(2, 2'd1, tim(1, 1, 2));
    cfg(2, 2'd2, tim(4, 0, 3));
    access(2, 1'b1, 20'h00010, 16'h1111, 0, 1'b0, 0);
    chk("R5", "write ce ext off", n_ce, 4);
    chk("R5", "write we ext off", n_we, 2);
    cfg(2, 2'd0, 16'h000F);
    access(2, 1'b1, 20'h00010, 16'h2222, 0, 1'b0, 0);
    chk("R5", "write ce ext on", n_ce, 7);
    chk("R5", "write we ext on", n_we, 3);
    access(2, 1'b0, 20'h00010, 16'h0, 0, 1'b0, 0);
    chk("R5", "read ce ext on", n_ce, 4);
    chk("R5", "read oe ext on", n_oe, 2);
  endtask

  task automatic t_narrow();
    cfg(3, 2'd0, 16'h0005);
    cfg(3, 2'd1, tim(1, 0, 2));
    access(3, 1'b0, 20'h00123, 16'h0, 0, 1'b0, 0);
    chk("R6", "narrow addr", 32'(cap_addr), 32'h00123);
    chk("R6", "narrow rdata", 32'(got_rdata), {24'h0, model(20'h123)[7:0]});
    access(3, 1'b1, 20'h00124, 16'hBEEF, 0, 1'b0, 0);
    chk("R6", "narrow wdata", 32'(cap_dq), 32'h00EF);
    chk("R11", "other selects", n_other, 0);
  endtask

  task automatic t_protect();
    cfg(1, 2'd0, 16'h0003);
    access(1, 1'b1, 20'h00040, 16'h5555, 0, 1'b0, 0);
    chk("R7", "protected write err", 32'(got_err), 32'd1);
    chk("R7", "protected write selects", n_any, 0);
    chk("R7", "protected write we", n_we, 0);
    access(1, 1'b0, 20'h00040, 16'h0, 0, 1'b0, 0);
    chk("R7", "read on protected bank err", 32'(got_err), 32'd0);
    chk("R7", "read on protected bank ce", n_ce, 4);
    cfg(3, 2'd0, 16'h0000);
    access(3, 1'b0, 20'h00040, 16'h0, 0, 1'b0, 0);
    chk("R7", "disabled bank err", 32'(got_err), 32'd1);
    chk("R7", "disabled bank selects", n_any, 0);
  endtask

  task automatic t_wait();
    cfg(0, 2'd1, tim(1, 0, 2));
    cfg(0, 2'd0, 16'h0017);
    access(0, 1'b0, 20'h00020, 16'h0, 4, 1'b0, 0);
    chk("R8", "active-low wait oe", n_oe, 5);
    chk("R8", "active-low wait ce", n_ce, 6);
    chk("R8", "rdata after wait", 32'(got_rdata), 32'(model(20'h10)));
    access(0, 1'b1, 20'h00020, 16'h7777, 2, 1'b0, 0);
    chk("R8", "write wait we", n_we, 3);
    cfg(0, 2'd0, 16'h0037);
    access(0, 1'b0, 20'h00020, 16'h0, 3, 1'b1, 0);
    chk("R8", "active-high wait oe", n_oe, 4);
    cfg(0, 2'd0, 16'h0007);
    access(0, 1'b0, 20'h00020, 16'h0, 4, 1'b0, 0);
    chk("R8", "wait disabled oe", n_oe, 2);
  endtask

  task automatic t_wait_reg();
    cfg(0, 2'd0, 16'h0057);
    access(0, 1'b0, 20'h00020, 16'h0, 4, 1'b0, 0);
    chk("R9", "delayed wait oe", n_oe, 6);
    access(0, 1'b0, 20'h00020, 16'h0, 0, 1'b0, 0);
    chk("R9", "delayed wait idle oe", n_oe, 2);
  endtask

  task automatic t_backpressure();
    cfg(0, 2'd0, 16'h0007);
    access(0, 1'b0, 20'h00030, 16'h0, 0, 1'b0, 3);
    chk("R10", "rdata", 32'(got_rdata), 32'(model(20'h18)));
    access(0, 1'b0, 20'h00032, 16'h0, 0, 1'b0, 0);
    chk("R10", "next access after held rsp", 32'(got_rdata), 32'(model(20'h19)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reset_cfg();
    t_read();
    t_write();
    t_zero();
    t_extended();
    t_narrow();
    t_protect();
    t_wait();
    t_wait_reg();
    t_backpressure();
    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
    $finish;
  end
endmodule